// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor with Return Stack

This block produces the address to fetch in the next cycle. It does this from the current fetch address alone, before the instruction has been decoded. A direct-mapped table, indexed by low bits of the fetch address, remembers the destination of jumps seen before. The same-cycle output is combinational. The target of a register-indirect jump is otherwise unknown until after register read, so this prediction lets fetch continue without a bubble.

Each table entry also records a jump-kind hint. The four kinds behave the same architecturally; they differ only in how the predictor treats them. Plain jumps and calls take their destination from the table, and a call also saves its return address on a small circular return stack. Returns take their destination from the top of that stack. A coroutine call takes the stack top and leaves its own return address in its place.

An external direction predictor supplies a taken bit. The execute stage writes resolved jumps back through an update port. Direction prediction and pipeline recovery sit outside this block.

Top module: `next_pc_predictor`

## Requirements
- R1: After reset no table entry is valid, so every lookup gives fetchPc+4, even with predTaken high.
- R2: The table has 64 entries. A lookup indexes it with fetchPc[7:2] and hits only when that entry is valid and its stored tag equals fetchPc[31:8]. A tag mismatch at the same index gives fetchPc+4.
- R3: With predTaken low, nextPc is fetchPc+4 and the return stack is left unchanged, whatever the entry holds.
- R4: When updValid is high at a clock edge, the entry at updPc[7:2] is written with tag, target and kind. It is valid from the next cycle on, and it replaces any earlier contents.
- R5: Kind encoding on updKind is 0 = plain jump, 1 = call, 2 = return, 3 = coroutine call. A taken hit on a plain jump gives the stored target and does not touch the stack.
- R6: A taken hit on a call gives the stored target and pushes fetchPc+4.
- R7: A taken hit on a return with a non-empty stack gives the stack top and pops it.
- R8: A taken hit on a return with an empty stack gives the stored target and leaves the stack empty.
- R9: A taken hit on a coroutine call with a non-empty stack gives the stack top and replaces it with fetchPc+4, keeping the depth. With an empty stack it gives the stored target and pushes fetchPc+4.
- R10: The stack holds 8 addresses. A push onto a full stack overwrites the oldest entry, so the last 8 pushed addresses come back in reverse order. After that the stack is empty.
- R11: A lookup in the same cycle as an update of the same entry sees the entry's old contents. The new contents appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Current fetch address (word aligned) |
| predTaken | input | 1 | Taken prediction from the direction predictor |
| updValid | input | 1 | Write the resolved jump into the table |
| updPc | input | 32 | Address of the resolved jump |
| updTarget | input | 32 | Resolved destination |
| updKind | input | 2 | Jump-kind hint (0 jump, 1 call, 2 return, 3 coroutine) |
| nextPc | output | 32 | Predicted next fetch address |

## Verification
A table update and a lookup can both reach the same entry in one cycle. A return whose entry is cached with an empty stack is rewritten as a plain jump to a new target, while the same address is fetched with predTaken high in that cycle. The check passes only if that cycle still yields the old fallback target and the next cycle yields the new one. A second overlap, a pop and a push in one edge, is driven by a coroutine call on a non-empty stack. It is judged by the order and number of addresses that later returns pull off the stack.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [1:0] {
    KIND_JUMP = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2,
    KIND_CORO = 2'd3
  } jumpKind_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic selStack;
    logic selTable;
  } npStrobes_t;
endpackage

// File: rtl/npp_return_stack.sv
module npp_return_stack #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushVal,
  output logic [ADDR_W-1:0] topVal,
  output logic              empty
);
  // DEPTH must be a power of two so the pointer wraps naturally.
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PW-1:0]     sp;
  logic [CW-1:0]     count;
  logic [PW-1:0]     topIdx;

  assign topIdx = sp - 1'b1;
  assign topVal = mem[topIdx];
  assign empty  = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= '0;
      count <= '0;
    end else begin
      case ({push, pop})
        2'b10: begin
          sp    <= sp + 1'b1;
          count <= (count == CW'(DEPTH)) ? count : count + 1'b1;
        end
        2'b01: begin
          sp    <= topIdx;
          count <= count - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop)     mem[sp]     <= pushVal;
    else if (push && pop) mem[topIdx] <= pushVal;
  end

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |-> count != '0);
  assert_replace_keeps_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/npp_control.sv
module npp_control
  import nextpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       predTaken,
  input  jumpKind_t  kind,
  input  logic       stackEmpty,
  output npStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (hit && predTaken) begin
      case (kind)
        KIND_JUMP: strobes.selTable = 1'b1;
        KIND_CALL: begin
          strobes.selTable = 1'b1;
          strobes.push     = 1'b1;
        end
        KIND_RET: begin
          strobes.selStack = !stackEmpty;
          strobes.selTable = stackEmpty;
          strobes.pop      = !stackEmpty;
        end
        KIND_CORO: begin
          strobes.selStack = !stackEmpty;
          strobes.selTable = stackEmpty;
          strobes.pop      = !stackEmpty;
          strobes.push     = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_quiet_when_not_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !predTaken |-> (strobes == '0));
  assert_single_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.selStack, strobes.selTable}));
endmodule

// File: rtl/npp_datapath.sv
module npp_datapath
  import nextpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 64,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic [1:0]        updKind,
  input  npStrobes_t        strobes,
  output logic              hit,
  output jumpKind_t         hitKind,
  output logic              stackEmpty,
  output logic [ADDR_W-1:0] nextPc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic              validQ [ENTRIES];
  logic [TAG_W-1:0]  tagQ   [ENTRIES];
  logic [ADDR_W-1:0] tgtQ   [ENTRIES];
  jumpKind_t         kindQ  [ENTRIES];

  logic [IDX_W-1:0]  fetchIdx, updIdx;
  logic [TAG_W-1:0]  fetchTag, updTag;
  logic [ADDR_W-1:0] seqPc, stackTop;
  logic [3:0]        unusedLowBits;

  assign fetchIdx      = fetchPc[IDX_W+1:2];
  assign fetchTag      = fetchPc[ADDR_W-1:IDX_W+2];
  assign updIdx        = updPc[IDX_W+1:2];
  assign updTag        = updPc[ADDR_W-1:IDX_W+2];
  assign unusedLowBits = {fetchPc[1:0], updPc[1:0]};
  assign seqPc         = fetchPc + ADDR_W'(4);

  assign hit     = validQ[fetchIdx] && (tagQ[fetchIdx] == fetchTag);
  assign hitKind = kindQ[fetchIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) validQ[i] <= 1'b0;
    end else if (updValid) begin
      validQ[updIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (updValid) begin
      tagQ[updIdx]  <= updTag;
      tgtQ[updIdx]  <= updTarget;
      kindQ[updIdx] <= jumpKind_t'(updKind);
    end
  end

  npp_return_stack #(.DEPTH(RAS_DEPTH), .ADDR_W(ADDR_W)) stack_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (strobes.push),
    .pop     (strobes.pop),
    .pushVal (seqPc),
    .topVal  (stackTop),
    .empty   (stackEmpty)
  );

  always_comb begin
    if (strobes.selStack)      nextPc = stackTop;
    else if (strobes.selTable) nextPc = tgtQ[fetchIdx];
    else                       nextPc = seqPc;
  end

  assert_update_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    updValid |=> validQ[$past(updIdx)]);
  assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (nextPc == fetchPc + ADDR_W'(4)));
endmodule

// File: rtl/next_pc_predictor.sv
module next_pc_predictor
  import nextpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 64,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              predTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic [1:0]        updKind,
  output logic [ADDR_W-1:0] nextPc
);
  npStrobes_t strobes;
  logic       hit, stackEmpty;
  jumpKind_t  hitKind;

  npp_control control_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .predTaken  (predTaken),
    .kind       (hitKind),
    .stackEmpty (stackEmpty),
    .strobes    (strobes)
  );

  npp_datapath #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .RAS_DEPTH(RAS_DEPTH)) datapath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchPc    (fetchPc),
    .updValid   (updValid),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .updKind    (updKind),
    .strobes    (strobes),
    .hit        (hit),
    .hitKind    (hitKind),
    .stackEmpty (stackEmpty),
    .nextPc     (nextPc)
  );
endmodule

// File: tb/next_pc_predictor_tb.sv
module next_pc_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predTaken = 1'b0;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic [1:0]  updKind = '0;
  logic [31:0] nextPc;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  next_pc_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .fetchPc(fetchPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget),
    .updKind(updKind), .nextPc(nextPc)
  );

  task automatic expectPc(input logic [31:0] exp, input string req);
    checks++;
    if (nextPc !== exp) begin
      errors++;
      $display("FAIL %s: nextPc=%h expected %h", req, nextPc, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic taken,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    updValid = 1'b0; fetchPc = pc; predTaken = taken;
    #1 expectPc(exp, req);
  endtask

  task automatic writeEntry(input logic [31:0] pc, input logic [31:0] tgt,
                            input logic [1:0] kind);
    @(negedge clk);
    predTaken = 1'b0; updValid = 1'b1; updPc = pc; updTarget = tgt; updKind = kind;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic testReset();
    lookup(32'h100, 1'b1, 32'h104, "R1");
    lookup(32'h1000, 1'b1, 32'h1004, "R1");
  endtask

  task automatic testJump();
    writeEntry(32'h1000, 32'h2000, 2'd0);
    lookup(32'h1000, 1'b1, 32'h2000, "R5");
    lookup(32'h1100, 1'b1, 32'h1104, "R2");
    lookup(32'h1000, 1'b0, 32'h1004, "R3");
    writeEntry(32'h1000, 32'h3000, 2'd0);
    lookup(32'h1000, 1'b1, 32'h3000, "R4");
  endtask

  task automatic testCallReturn();
    writeEntry(32'h1040, 32'h5550, 2'd2);
    lookup(32'h1040, 1'b1, 32'h5550, "R8");
    writeEntry(32'h1080, 32'h6000, 2'd1);
    lookup(32'h1080, 1'b1, 32'h6000, "R6");
    lookup(32'h1040, 1'b0, 32'h1044, "R3");
    lookup(32'h1040, 1'b1, 32'h1084, "R7");
    lookup(32'h1040, 1'b1, 32'h5550, "R8");
  endtask

  task automatic testCoroutine();
    writeEntry(32'h10C0, 32'h7000, 2'd3);
    lookup(32'h10C0, 1'b1, 32'h7000, "R9");
    lookup(32'h1080, 1'b1, 32'h6000, "R6");
    lookup(32'h10C0, 1'b1, 32'h1084, "R9");
    lookup(32'h1040, 1'b1, 32'h10C4, "R9");
    lookup(32'h1040, 1'b1, 32'h10C4, "R9");
    lookup(32'h1040, 1'b1, 32'h5550, "R9");
  endtask

  task automatic testOverflow();
    for (int k = 0; k < 9; k++)
      writeEntry(32'h2000 + 32'(4 * k), 32'h8000 + 32'(16 * k), 2'd1);
    for (int k = 0; k < 9; k++)
      lookup(32'h2000 + 32'(4 * k), 1'b1, 32'h8000 + 32'(16 * k), "R10");
    for (int j = 0; j < 8; j++)
      lookup(32'h1040, 1'b1, 32'h2004 + 32'(4 * (8 - j)), "R10");
    lookup(32'h1040, 1'b1, 32'h5550, "R10");
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    updValid = 1'b1; updPc = 32'h1040; updTarget = 32'h9990; updKind = 2'd0;
    fetchPc = 32'h1040; predTaken = 1'b1;
    #1 expectPc(32'h5550, "R11");
    @(negedge clk);
    updValid = 1'b0;
    #1 expectPc(32'h9990, "R11");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testJump();
    testCallReturn();
    testCoroutine();
    testOverflow();
    testSameCycle();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule